// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Attention Thresholds

This block holds the sample queues of a digital audio interface: one FIFO carries samples from software towards the serial transmitter, the other carries samples from the serial receiver back to software. Both are synchronous, 16 entries deep and 32 bits wide. The transmit side reports how many slots are still free, and the receive side reports how many slots hold data. Each side compares that figure with an attention threshold picked from a small encoded set (1, 4, 8 or 12 slots), so software or a DMA engine can wake only when a useful amount of work is waiting.

A pop of an empty transmit queue (underrun) or a push into a full receive queue (overrun) sets a sticky error flag, which stays set until software writes a one to it. A small register port sets the two threshold codes, issues the clear pulses, holds four interrupt enables and returns a status word. One interrupt output is the OR of the enabled sources: transmit level, receive level, transmit error and receive error.

Each FIFO tracks its fill through an occupancy state machine with three states. OCC_EMPTY goes to OCC_PARTIAL on an accepted push. OCC_PARTIAL goes to OCC_FULL when a lone push fills the last slot, and to OCC_EMPTY when a lone pop takes the last entry. OCC_FULL goes to OCC_PARTIAL on an accepted pop. A clear sends any state to OCC_EMPTY.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty (tx_free = 16, rx_fill = 0), both threshold codes are 0, all interrupt enables are 0, both error flags are 0, and irq is 0.
- R2: The transmit FIFO returns words in the order they were written. tx_rdata shows the oldest entry, and tx_free equals 16 minus the number of stored entries.
- R3: The receive FIFO returns words in the order they were written. rx_rdata shows the oldest entry, and rx_fill equals the number of stored entries.
- R4: A push into a full transmit FIFO and a pop from an empty receive FIFO are ignored. They leave the counts and the contents unchanged and set no error flag.
- R5: A pop from an empty transmit FIFO sets tx_err, and a push into a full receive FIFO sets rx_err without storing the word. Each flag stays set until cleared, and a new event in the same cycle as a clear wins.
- R6: Writing the register at address 2 clears tx_err where data bit 0 is 1 and rx_err where data bit 1 is 1. A 0 in either bit leaves that flag unchanged.
- R7: Threshold code 0, 1, 2 or 3 selects 1, 4, 8 or 12 slots. tx_level is 1 when tx_free is at least the transmit threshold, and rx_level is 1 when rx_fill is at least the receive threshold.
- R8: A write to address 0 sets the transmit code from data bits 2:1 and the receive code from bits 5:4. Bit 0 empties the transmit FIFO and bit 3 empties the receive FIFO, visible one cycle later. A clear overrides a push or pop in the same cycle and sets no error flag.
- R9: The register at address 1 holds the enables in bits 3:0 (transmit level, receive level, transmit error, receive error, in that bit order). irq is 1 only when an enabled source is 1.
- R10: ctl_rdata returns the codes at address 0 (same bit positions as written), the enables at address 1, and status at address 2: bit 0 tx_err, bit 1 rx_err, bit 2 tx_level, bit 3 rx_level, bits 12:8 tx_free, bits 20:16 rx_fill. Address 3 reads 0.
- R11: A push and a pop in the same cycle on a partly filled FIFO keep its count. On an empty transmit FIFO the push is taken and an underrun is flagged. On a full receive FIFO the pop is taken and an overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Software writes a word into the transmit FIFO |
| tx_wdata | input | 32 | Word to write into the transmit FIFO |
| tx_pop | input | 1 | Serial side takes the oldest transmit word |
| tx_rdata | output | 32 | Oldest transmit word |
| tx_free | output | 5 | Free slots in the transmit FIFO |
| tx_level | output | 1 | Transmit attention level reached |
| rx_push | input | 1 | Serial side writes a received word |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Software takes the oldest receive word |
| rx_rdata | output | 32 | Oldest receive word |
| rx_fill | output | 5 | Filled slots in the receive FIFO |
| rx_level | output | 1 | Receive attention level reached |
| ctl_wr | input | 1 | Register write strobe |
| ctl_addr | input | 2 | Register address |
| ctl_wdata | input | 6 | Register write data |
| ctl_rdata | output | 32 | Register read data for ctl_addr |
| tx_err | output | 1 | Sticky transmit underrun flag |
| rx_err | output | 1 | Sticky receive overrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check these properties: the count never goes past the depth, a clear leaves an empty FIFO, a push into a full FIFO or a pop from an empty one holds the count, the occupancy state agrees with the count, a set error flag stays set until written off, a fault always sets its flag, irq stays low while every enable is 0, and the level outputs are 0 at count zero and 1 at full depth. Only the bench scenarios can show data ordering, the exact code-to-threshold mapping, the register read layout, and the outcome of combined push, pop and clear in one cycle.

// File: rtl/afp_pkg.sv
package afp_pkg;

    // Occupancy states of one sample FIFO
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    // Register map of the control port
    localparam int CTL_AW = 2;
    localparam int CTL_WW = 6;
    localparam int CTL_RW = 32;
    localparam logic [CTL_AW-1:0] ADDR_CFG    = 2'd0;
    localparam logic [CTL_AW-1:0] ADDR_IRQEN  = 2'd1;
    localparam logic [CTL_AW-1:0] ADDR_STATUS = 2'd2;

    // Configuration word bit positions
    localparam int CFG_TX_CLR = 0;
    localparam int CFG_TX_LVL = 1;  // two bits
    localparam int CFG_RX_CLR = 3;
    localparam int CFG_RX_LVL = 4;  // two bits

    // Interrupt source order
    localparam int NSRC       = 4;
    localparam int SRC_TX_LVL = 0;
    localparam int SRC_RX_LVL = 1;
    localparam int SRC_TX_ERR = 2;
    localparam int SRC_RX_ERR = 3;

    // Status word field positions
    localparam int ST_FREE_LSB = 8;
    localparam int ST_FILL_LSB = 16;

    // Threshold code to slot count
    function automatic int lvl_slots(input logic [1:0] code);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/afp_fifo.sv
module afp_fifo
    import afp_pkg::*;
#(
    parameter int W         = 32,
    parameter int DEPTH     = 16,
    parameter bit POP_FAULT = 1'b1,   // 1: flag pop-on-empty, 0: flag push-on-full
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          fault
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_C  = CW'(DEPTH - 1);

    occ_e          st_q, st_d;
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          full, empty;
    logic          push_ok, pop_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OCC_EMPTY;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: begin
                if (!clr && push_ok)
                    st_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (clr)
                    st_d = OCC_EMPTY;
                else if (push_ok && !pop_ok && cnt_q == LAST_C)
                    st_d = OCC_FULL;
                else if (pop_ok && !push_ok && cnt_q == CW'(1))
                    st_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (clr)
                    st_d = OCC_EMPTY;
                else if (pop_ok)
                    st_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: st_d = OCC_EMPTY;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (st_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full  = 1'b1;
            default:     empty = 1'b1;
        endcase
        push_ok = push && !full;
        pop_ok  = pop  && !empty;
    end

    // Pointer and count datapath; clear wins over push and pop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Storage, not reset
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
    assign count = cnt_q;

    // Fault flavour picked per instance
    generate
        if (POP_FAULT) begin : g_pop_fault
            assign fault = pop && empty && !clr;
        end else begin : g_push_fault
            assign fault = push && full && !clr;
        end
    endgenerate

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);                                                          // R2
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));                                                     // R8
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == DEPTH_C && push && !pop && !clr) |=> $stable(cnt_q));             // R4
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push && !clr) |=> (cnt_q == '0));                   // R4
    AST_OCC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == OCC_EMPTY) == (cnt_q == '0)) && ((st_q == OCC_FULL) == (cnt_q == DEPTH_C))); // R2

endmodule

// File: rtl/afp_level.sv
module afp_level
    import afp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] metric,
    input  logic [1:0]    code,
    output logic          reached
);

    always_comb begin
        reached = (int'(metric) >= lvl_slots(code));
    end

    always_comb begin
        if (metric == '0)
            AST_LVL_ZERO: assert (!reached);                                        // R7
        if (int'(metric) == DEPTH)
            AST_LVL_FULLDEPTH: assert (reached);                                    // R7
    end

endmodule

// File: rtl/afp_regs.sv
module afp_regs
    import afp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [CTL_WW-1:0] ctl_wdata,
    output logic [CTL_RW-1:0] ctl_rdata,
    input  logic              tx_fault,
    input  logic              rx_fault,
    input  logic              tx_level,
    input  logic              rx_level,
    input  logic [CW-1:0]     tx_free,
    input  logic [CW-1:0]     rx_fill,
    output logic              tx_clr,
    output logic              rx_clr,
    output logic [1:0]        tx_code,
    output logic [1:0]        rx_code,
    output logic              tx_err,
    output logic              rx_err,
    output logic              irq
);

    logic            wr_cfg, wr_en, wr_st;
    logic [NSRC-1:0] irq_en, src;
    logic            tx_err_q, rx_err_q;

    assign wr_cfg = ctl_wr && (ctl_addr == ADDR_CFG);
    assign wr_en  = ctl_wr && (ctl_addr == ADDR_IRQEN);
    assign wr_st  = ctl_wr && (ctl_addr == ADDR_STATUS);

    // Clear pulses act in the cycle of the write
    assign tx_clr = wr_cfg && ctl_wdata[CFG_TX_CLR];
    assign rx_clr = wr_cfg && ctl_wdata[CFG_RX_CLR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_code <= '0;
            rx_code <= '0;
            irq_en  <= '0;
        end else begin
            if (wr_cfg) begin
                tx_code <= ctl_wdata[CFG_TX_LVL +: 2];
                rx_code <= ctl_wdata[CFG_RX_LVL +: 2];
            end
            if (wr_en) irq_en <= ctl_wdata[NSRC-1:0];
        end
    end

    // Sticky error flags: a new event beats a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_err_q <= 1'b0;
            rx_err_q <= 1'b0;
        end else begin
            if (tx_fault)                    tx_err_q <= 1'b1;
            else if (wr_st && ctl_wdata[0])  tx_err_q <= 1'b0;
            if (rx_fault)                    rx_err_q <= 1'b1;
            else if (wr_st && ctl_wdata[1])  rx_err_q <= 1'b0;
        end
    end

    assign tx_err = tx_err_q;
    assign rx_err = rx_err_q;

    always_comb begin
        src             = '0;
        src[SRC_TX_LVL] = tx_level;
        src[SRC_RX_LVL] = rx_level;
        src[SRC_TX_ERR] = tx_err_q;
        src[SRC_RX_ERR] = rx_err_q;
        irq             = |(src & irq_en);
    end

    // Read mux
    always_comb begin
        ctl_rdata = '0;
        unique case (ctl_addr)
            ADDR_CFG: begin
                ctl_rdata[CFG_TX_LVL +: 2] = tx_code;
                ctl_rdata[CFG_RX_LVL +: 2] = rx_code;
            end
            ADDR_IRQEN: ctl_rdata[NSRC-1:0] = irq_en;
            ADDR_STATUS: begin
                ctl_rdata[0]                = tx_err_q;
                ctl_rdata[1]                = rx_err_q;
                ctl_rdata[2]                = tx_level;
                ctl_rdata[3]                = rx_level;
                ctl_rdata[ST_FREE_LSB +: CW] = tx_free;
                ctl_rdata[ST_FILL_LSB +: CW] = rx_fill;
            end
            default: ctl_rdata = '0;
        endcase
    end

    AST_TX_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_q && !(wr_st && ctl_wdata[0])) |=> tx_err_q);                       // R6
    AST_RX_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_q && !(wr_st && ctl_wdata[1])) |=> rx_err_q);                       // R6
    AST_TX_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fault |=> tx_err_q);                                                     // R5
    AST_RX_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fault |=> rx_err_q);                                                     // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);                                                   // R9

endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
    import afp_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [W-1:0]      tx_wdata,
    input  logic              tx_pop,
    output logic [W-1:0]      tx_rdata,
    output logic [CW-1:0]     tx_free,
    output logic              tx_level,
    input  logic              rx_push,
    input  logic [W-1:0]      rx_wdata,
    input  logic              rx_pop,
    output logic [W-1:0]      rx_rdata,
    output logic [CW-1:0]     rx_fill,
    output logic              rx_level,
    input  logic              ctl_wr,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [CTL_WW-1:0] ctl_wdata,
    output logic [CTL_RW-1:0] ctl_rdata,
    output logic              tx_err,
    output logic              rx_err,
    output logic              irq
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic          tx_clr, rx_clr;
    logic          tx_fault, rx_fault;
    logic [1:0]    tx_code, rx_code;
    logic [CW-1:0] tx_cnt;

    afp_fifo #(.W(W), .DEPTH(DEPTH), .POP_FAULT(1'b1)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_cnt),
        .fault (tx_fault)
    );

    afp_fifo #(.W(W), .DEPTH(DEPTH), .POP_FAULT(1'b0)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_fill),
        .fault (rx_fault)
    );

    assign tx_free = DEPTH_C - tx_cnt;

    afp_level #(.DEPTH(DEPTH)) u_tx_level (
        .metric  (tx_free),
        .code    (tx_code),
        .reached (tx_level)
    );

    afp_level #(.DEPTH(DEPTH)) u_rx_level (
        .metric  (rx_fill),
        .code    (rx_code),
        .reached (rx_level)
    );

    afp_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_addr  (ctl_addr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .tx_fault  (tx_fault),
        .rx_fault  (rx_fault),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_free   (tx_free),
        .rx_fill   (rx_fill),
        .tx_clr    (tx_clr),
        .rx_clr    (rx_clr),
        .tx_code   (tx_code),
        .rx_code   (rx_code),
        .tx_err    (tx_err),
        .rx_err    (rx_err),
        .irq       (irq)
    );

    AST_TX_CLR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_err) |=> !tx_err);                                           // R8
    AST_RX_CLR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_err) |=> !rx_err);                                           // R8

endmodule

// File: tb/tb_audio_fifo_pair.sv
module tb_audio_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, ctl_wr = 0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [1:0]  ctl_addr = '0;
    logic [5:0]  ctl_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata, ctl_rdata;
    logic [4:0]  tx_free, rx_fill;
    logic        tx_level, rx_level, tx_err, rx_err, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    audio_fifo_pair dut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_free(tx_free), .tx_level(tx_level),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_fill(rx_fill), .rx_level(rx_level),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tx_err(tx_err), .rx_err(rx_err), .irq(irq)
    );

    // Stimulus table: op[44:42], arg[41:10], expected tx_free[9:5], expected rx_fill[4:0]
    // op: 0 tx write, 1 tx take, 2 rx write, 3 rx take, 4 config write
    localparam int NV = 12;
    localparam logic [44:0] VEC [NV] = '{
        {3'd0, 32'h0000_00A0, 5'd15, 5'd0},
        {3'd0, 32'h0000_00A1, 5'd14, 5'd0},
        {3'd1, 32'h0,         5'd15, 5'd0},
        {3'd2, 32'h0000_00B0, 5'd15, 5'd1},
        {3'd2, 32'h0000_00B1, 5'd15, 5'd2},
        {3'd2, 32'h0000_00B2, 5'd15, 5'd3},
        {3'd3, 32'h0,         5'd15, 5'd2},
        {3'd4, 32'h0000_0001, 5'd16, 5'd2},
        {3'd4, 32'h0000_0008, 5'd16, 5'd0},
        {3'd3, 32'h0,         5'd16, 5'd0},
        {3'd0, 32'h0000_00C0, 5'd15, 5'd0},
        {3'd4, 32'h0000_0009, 5'd16, 5'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic txw, input logic txr, input logic rxw, input logic rxr,
                       input logic cw, input logic [1:0] ca, input logic [5:0] cd,
                       input logic [31:0] td, input logic [31:0] rd);
        tx_push = txw; tx_pop = txr; rx_push = rxw; rx_pop = rxr;
        ctl_wr = cw; ctl_addr = ca; ctl_wdata = cd; tx_wdata = td; rx_wdata = rd;
        @(posedge clk); #1;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; ctl_wr = 0;
    endtask

    task automatic txw(input logic [31:0] d); cyc(1,0,0,0,0,2'd0,6'd0,d,32'h0); endtask
    task automatic txr();                     cyc(0,1,0,0,0,2'd0,6'd0,32'h0,32'h0); endtask
    task automatic rxw(input logic [31:0] d); cyc(0,0,1,0,0,2'd0,6'd0,32'h0,d); endtask
    task automatic rxr();                     cyc(0,0,0,1,0,2'd0,6'd0,32'h0,32'h0); endtask
    task automatic ctl(input logic [1:0] a, input logic [5:0] d); cyc(0,0,0,0,1,a,d,32'h0,32'h0); endtask

    task automatic rd_reg(input logic [1:0] a, input string req, input logic [31:0] exp);
        ctl_addr = a; #1;
        chk(req, ctl_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 tx_free", 32'(tx_free), 32'd16);
        chk("R1 rx_fill", 32'(rx_fill), 32'd0);
        chk("R1 errors", {30'h0, rx_err, tx_err}, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd_reg(2'd0, "R1 codes", 32'h0);
        rd_reg(2'd1, "R1 enables", 32'h0);
        rd_reg(2'd2, "R10 status after reset", 32'h0000_1004);

        // Table walk: R2 R3 R8 counts
        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            unique case (v[44:42])
                3'd0: txw(v[41:10]);
                3'd1: txr();
                3'd2: rxw(v[41:10]);
                3'd3: rxr();
                default: ctl(2'd0, v[15:10]);
            endcase
            chk("R2 table tx_free", 32'(tx_free), 32'(v[9:5]));
            chk("R3 table rx_fill", 32'(rx_fill), 32'(v[4:0]));
        end

        // R2 order
        txw(32'h11); txw(32'h22); txw(32'h33);
        chk("R2 head0", tx_rdata, 32'h11); txr();
        chk("R2 head1", tx_rdata, 32'h22); txr();
        chk("R2 head2", tx_rdata, 32'h33); txr();
        chk("R2 free", 32'(tx_free), 32'd16);

        // R3 order
        rxw(32'h44); rxw(32'h55);
        chk("R3 fill", 32'(rx_fill), 32'd2);
        chk("R3 head0", rx_rdata, 32'h44); rxr();
        chk("R3 head1", rx_rdata, 32'h55); rxr();
        chk("R3 empty", 32'(rx_fill), 32'd0);

        // R4 full transmit write ignored
        for (int i = 0; i < 16; i++) txw(32'h100 + 32'(i));
        chk("R4 tx full", 32'(tx_free), 32'd0);
        txw(32'hDEAD);
        chk("R4 tx full write", 32'(tx_free), 32'd0);
        chk("R4 no tx_err", 32'(tx_err), 32'd0);
        for (int i = 0; i < 15; i++) txr();
        chk("R4 last tx word", tx_rdata, 32'h10F);
        txr();
        chk("R4 tx drained", 32'(tx_free), 32'd16);

        // R5 underrun
        txr();
        chk("R5 underrun flag", 32'(tx_err), 32'd1);
        chk("R5 underrun free", 32'(tx_free), 32'd16);

        // R4 empty receive read ignored
        rxr();
        chk("R4 rx empty read", 32'(rx_fill), 32'd0);
        chk("R4 no rx_err", 32'(rx_err), 32'd0);

        // R5 overrun
        for (int i = 0; i < 16; i++) rxw(32'h200 + 32'(i));
        rxw(32'hBEEF);
        chk("R5 overrun fill", 32'(rx_fill), 32'd16);
        chk("R5 overrun flag", 32'(rx_err), 32'd1);
        for (int i = 0; i < 15; i++) rxr();
        chk("R5 overrun word dropped", rx_rdata, 32'h20F);
        rxr();
        chk("R5 tx_err still set", 32'(tx_err), 32'd1);

        // R6 write-one clear
        ctl(2'd2, 6'd0);
        chk("R6 zero keeps", {30'h0, rx_err, tx_err}, 32'h3);
        ctl(2'd2, 6'd1);
        chk("R6 clear tx", {30'h0, rx_err, tx_err}, 32'h2);
        ctl(2'd2, 6'd2);
        chk("R6 clear rx", {30'h0, rx_err, tx_err}, 32'h0);

        // R9 interrupt gating
        txr();
        chk("R9 masked", 32'(irq), 32'd0);
        ctl(2'd1, 6'b000100);
        chk("R9 tx err enabled", 32'(irq), 32'd1);
        rd_reg(2'd1, "R10 enables read", 32'h4);
        ctl(2'd2, 6'd1);
        chk("R9 source gone", 32'(irq), 32'd0);
        ctl(2'd1, 6'b000001);
        chk("R9 tx level enabled", 32'(irq), 32'd1);
        ctl(2'd1, 6'b000010);
        chk("R9 rx level low", 32'(irq), 32'd0);
        ctl(2'd1, 6'b000000);

        // R7 thresholds: tx code 3 (12), rx code 2 (8)
        ctl(2'd0, 6'h26);
        rd_reg(2'd0, "R10 codes read", 32'h26);
        chk("R7 tx 16>=12", 32'(tx_level), 32'd1);
        for (int i = 0; i < 4; i++) txw(32'(i));
        chk("R7 tx 12>=12", 32'(tx_level), 32'd1);
        txw(32'h9);
        chk("R7 tx 11<12", 32'(tx_level), 32'd0);
        for (int i = 0; i < 7; i++) rxw(32'(i));
        chk("R7 rx 7<8", 32'(rx_level), 32'd0);
        rxw(32'h7);
        chk("R7 rx 8>=8", 32'(rx_level), 32'd1);
        ctl(2'd0, 6'h16);
        chk("R7 rx code1 8>=4", 32'(rx_level), 32'd1);
        ctl(2'd0, 6'h34);
        chk("R7 tx code2 11>=8", 32'(tx_level), 32'd1);
        chk("R7 rx code3 8<12", 32'(rx_level), 32'd0);
        rd_reg(2'd2, "R10 status layout", 32'h0008_0B04);
        rd_reg(2'd3, "R10 unused address", 32'h0);

        // R8 clear beats push and pop
        cyc(0,0,1,0,1,2'd0,6'h3C,32'h0,32'h77);
        chk("R8 rx clear with push", 32'(rx_fill), 32'd0);
        chk("R8 rx no err", 32'(rx_err), 32'd0);
        cyc(0,1,0,0,1,2'd0,6'h35,32'h0,32'h0);
        chk("R8 tx clear with pop", 32'(tx_free), 32'd16);
        cyc(0,1,0,0,1,2'd0,6'h35,32'h0,32'h0);
        chk("R8 clear on empty no underrun", 32'(tx_err), 32'd0);
        rd_reg(2'd0, "R8 codes kept", 32'h34);

        // R11 simultaneous push and pop
        txw(32'hA); txw(32'hB);
        cyc(1,1,0,0,0,2'd0,6'd0,32'hC,32'h0);
        chk("R11 tx count kept", 32'(tx_free), 32'd14);
        chk("R11 tx head", tx_rdata, 32'hB);
        rxw(32'hD);
        cyc(0,0,1,1,0,2'd0,6'd0,32'h0,32'hE);
        chk("R11 rx count kept", 32'(rx_fill), 32'd1);
        chk("R11 rx head", rx_rdata, 32'hE);
        ctl(2'd0, 6'h35);
        cyc(1,1,0,0,0,2'd0,6'd0,32'hF,32'h0);
        chk("R11 tx empty both free", 32'(tx_free), 32'd15);
        chk("R11 tx empty both err", 32'(tx_err), 32'd1);
        for (int i = 0; i < 15; i++) rxw(32'h300 + 32'(i));
        cyc(0,0,1,1,0,2'd0,6'd0,32'h0,32'h5A5A);
        chk("R11 rx full both fill", 32'(rx_fill), 32'd15);
        chk("R11 rx full both err", 32'(rx_err), 32'd1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule